// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A host writes a byte with a one-cycle strobe. If the transmitter is enabled and idle, it accepts the byte and sends a frame in this order: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts a fixed number of baud ticks. The baud tick is a one-cycle enable that comes from a rate generator outside the block.

Four parity modes are available: none, a constant-zero bit, odd and even. A separate stop-length bit chooses one or two stop bits. The block takes the parity mode, the stop length and the data at the cycle it accepts a write, so a change to these inputs during a frame has no effect until the next frame. While the enable input is low, the line rests high and a pin-use output tells the surrounding logic that the pin is free for other uses. A one-cycle completion pulse marks the end of the last stop bit.

Top module: `sertx_core`

## Requirements
- R1: After reset `tx_line`=1, `tx_busy`=0, `tx_done`=0 and `tx_pin_active`=0. Whenever `tx_busy` is 0, `tx_line` is 1.
- R2: The block accepts a `wr_en` pulse only when `tx_enable`=1 and `tx_busy`=0. From the next cycle, `tx_busy`=1 and `tx_line` drives the start bit (0).
- R3: The frame order is: start bit 0, then the 8 data bits LSB first, then the parity bit if one is selected, then the stop bit(s) at 1. Each bit lasts TICKS_PER_BIT (16) baud ticks counted while busy, and `tx_line` changes only on a counted tick.
- R4: `parity_sel`=2'b00 sends no parity bit. `parity_sel`=2'b01 always sends a parity bit of 0.
- R5: `parity_sel`=2'b10 sends a parity bit that makes the count of ones in data plus parity odd. 2'b11 makes that count even.
- R6: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two, so a frame is 10 to 12 bits long.
- R7: A `wr_en` pulse while `tx_busy`=1 is ignored. The frame in flight is unchanged and no extra frame follows it.
- R8: Data, `parity_sel` and `two_stop` are captured at acceptance. Changing them during a frame does not alter that frame.
- R9: `tx_done` is a one-cycle pulse. It is raised in the same cycle that `tx_busy` falls, after the final tick of the last stop bit. A write presented in that cycle is accepted.
- R10: `tx_pin_active` equals `tx_enable` delayed by one cycle. A write while `tx_enable`=0 starts nothing, so `tx_line` stays 1 and `tx_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle baud enable, 16 per bit |
| wr_en | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character to send |
| tx_enable | input | 1 | Transmitter enable |
| parity_sel | input | 2 | 00 none, 01 zero, 10 odd, 11 even |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | One-cycle pulse at frame end |
| tx_pin_active | output | 1 | Pin is in serial use |

## Verification
Two events can fall in the same cycle: the completion pulse of one frame and the acceptance of the next write. The bench raises the write strobe in the very cycle that `tx_done` is high. It then checks three things: that `tx_busy` returns high on the next edge, that the start bit follows at once, and that the second frame is sent bit for bit. A second case overlaps a write and configuration changes with a frame in flight, and is judged on the serial bits seen at mid-bit and on the absence of a follow-on frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_t;
endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  assign bit_end = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  par_mode_t          par,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  localparam int PAR_POS = DATA_W + 1;

  logic has_par;
  logic par_bit;

  always_comb begin
    has_par = (par != PAR_NONE);
    unique case (par)
      PAR_ODD:  par_bit = ~(^data);
      PAR_EVEN: par_bit = ^data;
      default:  par_bit = 1'b0;
    endcase
    // Unused positions stay 1 so they act as stop bits.
    frame             = '1;
    frame[0]          = 1'b0;
    frame[DATA_W:1]   = data;
    if (has_par) frame[PAR_POS] = par_bit;
    len = LEN_W'(DATA_W + 2) + LEN_W'(has_par) + LEN_W'(two_stop);
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic [1:0]        parity_sel,
  input  logic              two_stop,
  output logic              tx_line,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_pin_active
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic [FRAME_W-2:0] rest;
  logic [LEN_W-1:0]   bits_left;
  logic               accept;
  logic               bit_end;

  assign accept = wr_en && tx_enable && !tx_busy;

  sertx_frame_build #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_build (
    .data    (wr_data),
    .par     (par_mode_t'(parity_sel)),
    .two_stop(two_stop),
    .frame   (frame),
    .len     (len)
  );

  sertx_bit_timer #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .tick   (baud_tick && tx_busy),
    .bit_end(bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line       <= 1'b1;
      tx_busy       <= 1'b0;
      tx_done       <= 1'b0;
      tx_pin_active <= 1'b0;
      rest          <= '1;
      bits_left     <= '0;
    end else begin
      tx_pin_active <= tx_enable;
      tx_done       <= 1'b0;
      if (accept) begin
        tx_line   <= frame[0];
        rest      <= frame[FRAME_W-1:1];
        bits_left <= len;
        tx_busy   <= 1'b1;
      end else if (bit_end) begin
        if (bits_left == LEN_W'(1)) begin
          tx_busy <= 1'b0;
          tx_done <= 1'b1;
          tx_line <= 1'b1;
        end else begin
          tx_line   <= rest[0];
          rest      <= {1'b1, rest[FRAME_W-2:1]};
          bits_left <= bits_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic tx_enable,
  input logic tx_line,
  input logic tx_busy,
  input logic tx_done,
  input logic tx_pin_active
);
  // R1
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);
  // R2
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !tx_line);
  // R3
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !baud_tick) |=> $stable(tx_line));
  // R9
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  // R9
  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> tx_done);
  // R9
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !tx_busy);
  // R10
  assert_pin_active_R10: assert property (@(posedge clk) disable iff (rst)
    tx_enable |=> tx_pin_active);
  // R10
  assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> $past(tx_enable));
endmodule

bind sertx_core sertx_core_chk u_chk (.*);

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b0;
  logic [1:0] parity_sel = 2'b00;
  logic       two_stop = 1'b0;
  logic       tx_line, tx_busy, tx_done, tx_pin_active;

  int n_checks = 0;
  int n_fail   = 0;

  sertx_core u_sertx_core (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .tx_enable(tx_enable), .parity_sel(parity_sel),
    .two_stop(two_stop), .tx_line(tx_line), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_pin_active(tx_pin_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // baud tick every 4 clocks, changed on falling edges
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  // vectors: [10:3] data, [2:1] parity mode, [0] two stop bits
  localparam logic [10:0] VEC [6] = '{
    {8'h00, 2'b00, 1'b0},
    {8'hA5, 2'b01, 1'b0},
    {8'h01, 2'b10, 1'b0},
    {8'h03, 2'b10, 1'b1},
    {8'h07, 2'b11, 1'b0},
    {8'hFF, 2'b11, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int cnt = 0;
    while (cnt < n) begin
      @(posedge clk);
      if (baud_tick) cnt++;
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // expected serial bits built from the frame rules
  task automatic expect_frame(input logic [7:0] d, input logic [1:0] p,
                              input logic s, output logic [11:0] bits,
                              output int len);
    int ones = 0;
    bits = '1;
    len = 0;
    bits[len] = 1'b0; len++;
    for (int i = 0; i < 8; i++) begin
      bits[len] = d[i]; len++;
      ones += d[i];
    end
    if (p == 2'b01) begin bits[len] = 1'b0; len++; end
    if (p == 2'b10) begin bits[len] = (ones % 2 == 0); len++; end
    if (p == 2'b11) begin bits[len] = (ones % 2 == 1); len++; end
    len += 1 + int'(s);
  endtask

  // called right after the acceptance edge; returns just after the done edge
  task automatic capture(input logic [7:0] d, input logic [1:0] p,
                         input logic s, input string req);
    logic [11:0] e;
    int len;
    expect_frame(d, p, s, e, len);
    for (int i = 0; i < len; i++) begin
      wait_ticks(HALF_BIT);
      #1;
      check(tx_line === e[i], req, $sformatf("bit %0d of %0d", i, len),
            int'(tx_line), int'(e[i]));
      if (i == len - 1)
        check(tx_busy === 1'b1, "R6", "busy during last stop bit", int'(tx_busy), 1);
      wait_ticks(HALF_BIT);
    end
    #1;
    check(tx_done === 1'b1 && tx_busy === 1'b0 && tx_line === 1'b1, "R9",
          "done pulse at frame end", {tx_done, tx_busy, tx_line}, 3'b101);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(tx_line === 1'b1 && tx_busy === 1'b0 && tx_done === 1'b0 &&
          tx_pin_active === 1'b0, "R1", "reset state",
          {tx_line, tx_busy, tx_done, tx_pin_active}, 4'b1000);
    @(negedge clk);
    rst = 1'b0;

    // R10: write while disabled starts nothing
    send(8'h3C);
    repeat (20) @(posedge clk);
    #1;
    check(tx_busy === 1'b0 && tx_line === 1'b1 && tx_pin_active === 1'b0,
          "R10", "write while disabled", {tx_busy, tx_line, tx_pin_active}, 3'b010);

    @(negedge clk);
    tx_enable = 1'b1;
    @(posedge clk);
    #1;
    check(tx_pin_active === 1'b1, "R10", "pin active after enable",
          int'(tx_pin_active), 1);

    // vector table: R3 order, R4/R5 parity, R6 stop length
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      logic [1:0] p;
      logic       s;
      d = VEC[v][10:3];
      p = VEC[v][2:1];
      s = VEC[v][0];
      @(negedge clk);
      parity_sel = p;
      two_stop   = s;
      send(d);
      check(tx_busy === 1'b1 && tx_line === 1'b0, "R2", "start after accept",
            {tx_busy, tx_line}, 2'b10);
      capture(d, p, s, (p[1] ? "R5" : "R4"));
      @(posedge clk);
      #1;
      check(tx_done === 1'b0, "R9", "done lasts one cycle", int'(tx_done), 0);
    end

    // R7 and R8: write and config change while a frame is in flight
    @(negedge clk);
    parity_sel = 2'b00;
    two_stop   = 1'b0;
    send(8'h55);
    fork
      capture(8'h55, 2'b00, 1'b0, "R8");
      begin
        repeat (60) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h00;
        parity_sel = 2'b11;
        two_stop = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
      end
    join
    repeat (80) @(posedge clk);
    #1;
    check(tx_busy === 1'b0 && tx_line === 1'b1, "R7",
          "no frame after ignored write", {tx_busy, tx_line}, 2'b01);

    // R9: write in the completion cycle is accepted (config now even, two stop)
    send(8'h81);
    capture(8'h81, 2'b11, 1'b1, "R5");
    @(negedge clk);
    check(tx_done === 1'b1, "R9", "done high when write presented", int'(tx_done), 1);
    wr_en = 1'b1;
    wr_data = 8'h6E;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check(tx_busy === 1'b1 && tx_line === 1'b0 && tx_done === 1'b0, "R9",
          "back-to-back start", {tx_busy, tx_line, tx_done}, 3'b100);
    capture(8'h6E, 2'b11, 1'b1, "R3");

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule